// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a virtual address that missed in the TLB. It walks a two-level, short-format translation table held in memory. A walk begins with a single request that carries the 32-bit virtual address, an access kind (read, write or fetch) and an address-space identifier. The walker picks one of two table base registers. The choice depends on a configurable split width N. The walker then fetches the first-level word over a simple valid/ready memory request channel. A response comes back on a valid-only channel. If the first-level word points to a second-level table, the walker fetches the second-level word the same way.

The decoded result leaves the block in one of two forms. One is a TLB fill entry: page frame, virtual page, size mask, global, execute-never, access permissions, domain, ASID, raw type/cache bits and shareable bit. The other is a fault, with its class and the table level. Either result is shown for exactly one cycle, and then the walker is ready for the next request. Only one walk can be in flight at a time. A request that arrives while a walk is in flight is flagged as a protocol error and is not accepted.

Top module: `pt_walk_unit`

## Requirements
- R1: If `cfg_split` is 0, or if VA bits [31:32-N] are all zero, the walk uses `cfg_base0` with N as given. Otherwise it uses `cfg_base1` and treats N as 0.
- R2: The first-level read address is base[31:14-N], then VA[31-N:20], then two zero bits.
- R3: A first-level word whose bits [1:0] are 00 or 11 gives a translation fault (`fault_kind`=1) at level 0. `fault_fetch` is set when `req_kind`=2 (fetch), and `fault_write` is set when `req_kind`=1 (write).
- R4: A first-level word with bits [1:0]=10 is a 1 MB section. The fill gives pfn=word[31:20], vpn=VA[31:20], size 0xFFFFF and `fill_section`=1. Its global flag is the inverse of bit 17. It also carries xn=bit 4, ap={bit15,bits11:10}, domain=bits 8:5, texcb={bits14:12,bit3,bit2} and shareable=bit 16.
- R5: When `cfg_afe` is 1 and AP[0] is 0, the walk gives an access-flag fault (`fault_kind`=2). AP[0] is bit 10 in a section, where the fault is at level 0, and bit 4 in a page, where the fault is at level 1. When `cfg_afe` is 0, AP[0] has no effect.
- R6: A first-level word with bits [1:0]=01 points to a second-level table. The second-level read address is word[31:10], then VA[19:12], then two zero bits.
- R7: A second-level word with bits [1:0]=00 gives a translation fault at level 1. `fault_domain` carries bits 8:5 of the first-level word.
- R8: A second-level word with bits [1:0]=01 is a 64 KB page: pfn=word[31:16], vpn=VA[31:16], size 0xFFFF, xn=bit 15, TEX=bits 14:12. With bit 1 set it is a 4 KB page: pfn=word[31:12], vpn=VA[31:12], size 0xFFF, xn=bit 0, TEX=bits 8:6. Both use ap={bit9,bits5:4}, shareable=bit 10 and global=!bit 11, and both take the domain from the first-level word.
- R9: A section with bit 18 set is a supersection. It gives an unsupported fault (`fault_kind`=3) at level 0 and takes priority over the access-flag check.
- R10: A `req_valid` that arrives while `busy` is high raises `req_err` in that cycle. It does not change the walk in progress.
- R11: Each walk ends with exactly one one-cycle pulse on `fill_valid` or on `fault_valid`. The cycle after that pulse, `busy` is low.
- R12: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request strobe |
| req_va | input | 32 | Virtual address to translate |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_asid | input | ASID_W | Address-space identifier |
| req_err | output | 1 | Request seen while busy |
| busy | output | 1 | Walk in flight |
| cfg_split | input | 3 | Split width N |
| cfg_base0 | input | 32 | Table base for low addresses |
| cfg_base1 | input | 32 | Table base for high addresses |
| cfg_afe | input | 1 | Access-flag fault enable |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Descriptor word address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| fill_valid | output | 1 | Fill entry pulse |
| fill_vpn | output | 20 | Virtual page number |
| fill_pfn | output | 20 | Physical frame number |
| fill_size | output | 20 | Offset mask |
| fill_section | output | 1 | Entry is a section |
| fill_global | output | 1 | Entry is global |
| fill_xn | output | 1 | Execute-never |
| fill_ap | output | 3 | Access permissions |
| fill_domain | output | 4 | Domain |
| fill_asid | output | ASID_W | Address-space identifier |
| fill_texcb | output | 5 | Raw type and cache bits |
| fill_shared | output | 1 | Shareable |
| fault_valid | output | 1 | Fault pulse |
| fault_kind | output | 2 | 1 translation, 2 access flag, 3 unsupported |
| fault_level | output | 1 | 0 first level, 1 second level |
| fault_fetch | output | 1 | Instruction-side abort |
| fault_write | output | 1 | Faulting access was a write |
| fault_domain | output | 4 | Domain for second-level translation faults |
| fault_va | output | 32 | Faulting virtual address |

## Verification
The vector table runs one walk of each outcome: a section, a large page, a small page, and faults of every kind and level. It also covers both base registers and the largest split. A wrong split choice or wrong index masking shows up as a bad first-level address. Field bit positions that were swapped show up as wrong xn, TEX, ap or global values in the full-field walks. One walk sets the supersection bit and also has AP[0]=0 with the access-flag check enabled, so a design that checks in the wrong order reports the access-flag fault instead. Further walks cover a request that arrives mid-walk, and a memory port that holds off acceptance for several cycles. A design that reloads state or lets go of its request would give the wrong page or a moving address.

// File: rtl/pt_walk_unit.sv
module pt_walk_unit #(
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_va,
  input  logic [1:0]        req_kind,
  input  logic [ASID_W-1:0] req_asid,
  output logic              req_err,
  output logic              busy,
  input  logic [2:0]        cfg_split,
  input  logic [31:0]       cfg_base0,
  input  logic [31:0]       cfg_base1,
  input  logic              cfg_afe,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              fill_valid,
  output logic [19:0]       fill_vpn,
  output logic [19:0]       fill_pfn,
  output logic [19:0]       fill_size,
  output logic              fill_section,
  output logic              fill_global,
  output logic              fill_xn,
  output logic [2:0]        fill_ap,
  output logic [3:0]        fill_domain,
  output logic [ASID_W-1:0] fill_asid,
  output logic [4:0]        fill_texcb,
  output logic              fill_shared,
  output logic              fault_valid,
  output logic [1:0]        fault_kind,
  output logic              fault_level,
  output logic              fault_fetch,
  output logic              fault_write,
  output logic [3:0]        fault_domain,
  output logic [31:0]       fault_va
);

  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_DONE, S_FAULT
  } state_t;

  localparam logic [1:0] FK_XLAT  = 2'd1;
  localparam logic [1:0] FK_AFLAG = 2'd2;
  localparam logic [1:0] FK_UNSUP = 2'd3;

  state_t state;
  logic [31:0] va_q;
  logic        fetch_q, write_q, afe_q;
  logic [3:0]  l1dom_q;

  logic        use_hi;
  logic [2:0]  eff_n;
  logic [31:0] base_sel, l1_addr;
  logic [11:0] l1_idx;
  logic [31:0] d;

  assign use_hi   = (cfg_split != 3'd0) && ((req_va >> (6'd32 - {3'd0, cfg_split})) != 32'd0);
  assign eff_n    = use_hi ? 3'd0 : cfg_split;
  assign base_sel = use_hi ? cfg_base1 : cfg_base0;
  assign l1_idx   = req_va[31:20] & (12'hFFF >> eff_n);
  assign l1_addr  = (base_sel & (32'hFFFF_FFFF << (5'd14 - {2'd0, eff_n}))) | {18'd0, l1_idx, 2'b00};
  assign d        = mem_rsp_data;

  assign busy          = (state != S_IDLE);
  assign req_err       = req_valid && busy;
  assign mem_req_valid = (state == S_L1_REQ) || (state == S_L2_REQ);
  assign fill_valid    = (state == S_DONE);
  assign fault_valid   = (state == S_FAULT);
  assign fault_va      = va_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      va_q         <= '0;
      fetch_q      <= 1'b0;
      write_q      <= 1'b0;
      afe_q        <= 1'b0;
      l1dom_q      <= '0;
      mem_req_addr <= '0;
      fill_vpn     <= '0;
      fill_pfn     <= '0;
      fill_size    <= '0;
      fill_section <= 1'b0;
      fill_global  <= 1'b0;
      fill_xn      <= 1'b0;
      fill_ap      <= '0;
      fill_domain  <= '0;
      fill_asid    <= '0;
      fill_texcb   <= '0;
      fill_shared  <= 1'b0;
      fault_kind   <= '0;
      fault_level  <= 1'b0;
      fault_fetch  <= 1'b0;
      fault_write  <= 1'b0;
      fault_domain <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q         <= req_va;
          fetch_q      <= (req_kind == 2'd2);
          write_q      <= (req_kind == 2'd1);
          afe_q        <= cfg_afe;
          fill_asid    <= req_asid;
          mem_req_addr <= l1_addr;
          state        <= S_L1_REQ;
        end
        S_L1_REQ: if (mem_req_ready) state <= S_L1_WAIT;
        S_L2_REQ: if (mem_req_ready) state <= S_L2_WAIT;
        S_L1_WAIT: if (mem_rsp_valid) begin
          fault_fetch  <= fetch_q;
          fault_write  <= write_q;
          fault_level  <= 1'b0;
          fault_domain <= 4'd0;
          case (d[1:0])
            2'b01: begin
              mem_req_addr <= {d[31:10], va_q[19:12], 2'b00};
              l1dom_q      <= d[8:5];
              state        <= S_L2_REQ;
            end
            2'b10: begin
              if (d[18]) begin
                fault_kind <= FK_UNSUP;
                state      <= S_FAULT;
              end else if (afe_q && !d[10]) begin
                fault_kind <= FK_AFLAG;
                state      <= S_FAULT;
              end else begin
                fill_pfn     <= {8'd0, d[31:20]};
                fill_vpn     <= {8'd0, va_q[31:20]};
                fill_size    <= 20'hFFFFF;
                fill_section <= 1'b1;
                fill_global  <= !d[17];
                fill_xn      <= d[4];
                fill_ap      <= {d[15], d[11:10]};
                fill_domain  <= d[8:5];
                fill_texcb   <= {d[14:12], d[3:2]};
                fill_shared  <= d[16];
                state        <= S_DONE;
              end
            end
            default: begin
              fault_kind <= FK_XLAT;
              state      <= S_FAULT;
            end
          endcase
        end
        S_L2_WAIT: if (mem_rsp_valid) begin
          fault_level <= 1'b1;
          if (d[1:0] == 2'b00) begin
            fault_kind   <= FK_XLAT;
            fault_domain <= l1dom_q;
            state        <= S_FAULT;
          end else if (afe_q && !d[4]) begin
            fault_kind   <= FK_AFLAG;
            fault_domain <= 4'd0;
            state        <= S_FAULT;
          end else begin
            if (d[1]) begin
              fill_pfn   <= d[31:12];
              fill_vpn   <= va_q[31:12];
              fill_size  <= 20'h00FFF;
              fill_xn    <= d[0];
              fill_texcb <= {d[8:6], d[3:2]};
            end else begin
              fill_pfn   <= {4'd0, d[31:16]};
              fill_vpn   <= {4'd0, va_q[31:16]};
              fill_size  <= 20'h0FFFF;
              fill_xn    <= d[15];
              fill_texcb <= {d[14:12], d[3:2]};
            end
            fill_section <= 1'b0;
            fill_global  <= !d[11];
            fill_ap      <= {d[9], d[5:4]};
            fill_domain  <= l1dom_q;
            fill_shared  <= d[10];
            state        <= S_DONE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_walk_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(va_q));

  assert_fill_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid || fault_valid) |=> (!fill_valid && !fault_valid && !busy));

  assert_section_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_section) |-> (fill_size == 20'hFFFFF));

  assert_unsup_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && fault_kind == FK_UNSUP) |-> !fault_level);

  assert_l2_domain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && fault_level && fault_kind == FK_XLAT) |-> (fault_domain == l1dom_q));

endmodule

// File: tb/test_pt_walk_unit.sv
`timescale 1ns/1ps
module test_pt_walk_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 0, cfg_afe = 0, mem_req_ready = 0, mem_rsp_valid = 0;
  logic [31:0] req_va = 0, cfg_base0 = 32'h4000_0000, cfg_base1 = 32'h8000_0000, mem_rsp_data = 0;
  logic [1:0]  req_kind = 0;
  logic [7:0]  req_asid = 0;
  logic [2:0]  cfg_split = 0;
  logic        req_err, busy, mem_req_valid, fill_valid, fill_section, fill_global, fill_xn, fill_shared;
  logic        fault_valid, fault_level, fault_fetch, fault_write;
  logic [31:0] mem_req_addr, fault_va;
  logic [19:0] fill_vpn, fill_pfn, fill_size;
  logic [2:0]  fill_ap;
  logic [3:0]  fill_domain, fault_domain;
  logic [7:0]  fill_asid;
  logic [4:0]  fill_texcb;
  logic [1:0]  fault_kind;

  pt_walk_unit #(.ASID_W(8)) i_pt_walk_unit (.*);

  int n_chk = 0, n_bad = 0;

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] va; logic [1:0] kind; logic [2:0] split; logic afe;
    logic [31:0] l1; logic [31:0] l2; logic [31:0] ea1; logic [31:0] ea2;
    logic [1:0] efk; logic elv; logic [19:0] epfn; logic [19:0] esize;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{32'h1234_5678, 2'd0, 3'd0, 1'b0, 32'hABC0_0402, 32'h0,         32'h4000_048C, 32'h0,         2'd0, 1'b0, 20'h00ABC, 20'hFFFFF},
    '{32'h0010_3000, 2'd0, 3'd0, 1'b0, 32'h0055_5421, 32'h7654_3012, 32'h4000_0004, 32'h0055_540C, 2'd0, 1'b0, 20'h76543, 20'h00FFF},
    '{32'h0020_5000, 2'd0, 3'd0, 1'b0, 32'h0066_6001, 32'h9876_0011, 32'h4000_0008, 32'h0066_6014, 2'd0, 1'b0, 20'h09876, 20'h0FFFF},
    '{32'h0030_0000, 2'd2, 3'd0, 1'b0, 32'h0000_0000, 32'h0,         32'h4000_000C, 32'h0,         2'd1, 1'b0, 20'h0,     20'h0},
    '{32'h0031_0000, 2'd1, 3'd0, 1'b0, 32'h0000_0003, 32'h0,         32'h4000_000C, 32'h0,         2'd1, 1'b0, 20'h0,     20'h0},
    '{32'h0040_1000, 2'd0, 3'd0, 1'b0, 32'h0077_7021, 32'h0,         32'h4000_0010, 32'h0077_7004, 2'd1, 1'b1, 20'h0,     20'h0},
    '{32'h0050_0000, 2'd1, 3'd0, 1'b1, 32'hABC0_0002, 32'h0,         32'h4000_0014, 32'h0,         2'd2, 1'b0, 20'h0,     20'h0},
    '{32'h0060_2000, 2'd0, 3'd0, 1'b1, 32'h0055_5421, 32'h7654_3002, 32'h4000_0018, 32'h0055_5408, 2'd2, 1'b1, 20'h0,     20'h0},
    '{32'h0070_0000, 2'd0, 3'd0, 1'b0, 32'h1110_0002, 32'h0,         32'h4000_001C, 32'h0,         2'd0, 1'b0, 20'h00111, 20'hFFFFF},
    '{32'h0080_0000, 2'd0, 3'd0, 1'b1, 32'h0004_0002, 32'h0,         32'h4000_0020, 32'h0,         2'd3, 1'b0, 20'h0,     20'h0},
    '{32'h3000_0000, 2'd0, 3'd2, 1'b0, 32'h2220_0402, 32'h0,         32'h4000_0C00, 32'h0,         2'd0, 1'b0, 20'h00222, 20'hFFFFF},
    '{32'hC010_0000, 2'd0, 3'd2, 1'b0, 32'h3330_0402, 32'h0,         32'h8000_3004, 32'h0,         2'd0, 1'b0, 20'h00333, 20'hFFFFF},
    '{32'h0150_0000, 2'd0, 3'd7, 1'b0, 32'h4440_0402, 32'h0,         32'h4000_0054, 32'h0,         2'd0, 1'b0, 20'h00444, 20'hFFFFF}
  };

  logic        r_fill, r_fault, r_lvl, r_fetch, r_write, r_sect, r_glob, r_xn, r_sh, stable_err, pulse_ok;
  logic [1:0]  r_kind;
  logic [3:0]  r_fdom, r_dom;
  logic [31:0] r_fva, a1, a2;
  logic [19:0] r_pfn, r_size, r_vpn;
  logic [2:0]  r_ap;
  logic [7:0]  r_asid;
  logic [4:0]  r_texcb;
  logic        r_err;

  task automatic do_walk(input logic [31:0] va, input logic [1:0] kind, input logic [2:0] split,
                         input logic afe, input logic [31:0] l1, input logic [31:0] l2,
                         input int stall, input logic intrude);
    int nreq = 0;
    logic pend = 0, done = 0, have_prev = 0;
    logic [31:0] prev = 0;
    int stall_left = stall;
    r_fill = 0; r_fault = 0; a1 = 0; a2 = 0; stable_err = 0; r_err = 0;
    @(negedge clk);
    req_valid = 1; req_va = va; req_kind = kind; cfg_split = split; cfg_afe = afe; req_asid = 8'h5A;
    @(negedge clk);
    req_valid = 0;
    if (intrude) begin
      req_valid = 1; req_va = 32'hFFFF_FFFF; cfg_split = 3'd0;
      #0.5 r_err = req_err;
    end
    for (int cyc = 0; cyc < 60 && !done; cyc++) begin
      mem_rsp_valid = 0;
      if (pend) begin
        mem_rsp_valid = 1; mem_rsp_data = (nreq == 1) ? l1 : l2; pend = 0;
      end else if (fill_valid || fault_valid) begin
        r_fill = fill_valid; r_fault = fault_valid; r_kind = fault_kind; r_lvl = fault_level;
        r_fetch = fault_fetch; r_write = fault_write; r_fdom = fault_domain; r_fva = fault_va;
        r_pfn = fill_pfn; r_size = fill_size; r_vpn = fill_vpn; r_sect = fill_section;
        r_glob = fill_global; r_xn = fill_xn; r_ap = fill_ap; r_dom = fill_domain;
        r_asid = fill_asid; r_texcb = fill_texcb; r_sh = fill_shared;
        done = 1;
      end else if (mem_req_valid) begin
        if (have_prev && mem_req_addr !== prev) stable_err = 1;
        prev = mem_req_addr; have_prev = 1;
        if (stall_left > 0) begin
          mem_req_ready = 0; stall_left--;
        end else begin
          mem_req_ready = 1; nreq++; have_prev = 0;
          if (nreq == 1) a1 = mem_req_addr; else a2 = mem_req_addr;
          pend = 1;
        end
      end
      @(negedge clk);
      req_valid = 0;
    end
    pulse_ok = !fill_valid && !fault_valid && !busy;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R11 actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11 reset busy", {31'd0, busy}, 32'd0);
    check("R11 reset fill/fault", {30'd0, fill_valid, fault_valid}, 32'd0);
    check("R12 reset mem_req_valid", {31'd0, mem_req_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      do_walk(TBL[i].va, TBL[i].kind, TBL[i].split, TBL[i].afe, TBL[i].l1, TBL[i].l2, 0, 1'b0);
      check((i >= 10) ? "R1 base select" : "R2 l1 addr", a1, TBL[i].ea1);
      if (TBL[i].ea2 != 0) check("R6 l2 addr", a2, TBL[i].ea2);
      check("R11 result pulse", {31'd0, pulse_ok}, 32'd1);
      if (TBL[i].efk == 2'd0) begin
        tag = (TBL[i].esize == 20'hFFFFF) ? "R4 section" : "R8 page";
        check(tag, {31'd0, r_fill}, 32'd1);
        check(tag, {12'd0, r_pfn}, {12'd0, TBL[i].epfn});
        check(tag, {12'd0, r_size}, {12'd0, TBL[i].esize});
      end else begin
        case (TBL[i].efk)
          2'd1: tag = TBL[i].elv ? "R7 l2 xlat" : "R3 l1 xlat";
          2'd2: tag = "R5 access flag";
          default: tag = "R9 supersection";
        endcase
        check(tag, {31'd0, r_fault}, 32'd1);
        check(tag, {29'd0, r_kind, r_lvl}, {29'd0, TBL[i].efk, TBL[i].elv});
      end
    end

    // R3: fetch vs write indication on first-level faults
    do_walk(32'h0030_0000, 2'd2, 3'd0, 1'b0, 32'h0, 32'h0, 0, 1'b0);
    check("R3 fetch flags", {30'd0, r_fetch, r_write}, 32'b10);
    do_walk(32'h0030_0000, 2'd1, 3'd0, 1'b0, 32'h3, 32'h0, 0, 1'b0);
    check("R3 write flags", {30'd0, r_fetch, r_write}, 32'b01);

    // R4: all section fields
    do_walk(32'hABC5_4321, 2'd0, 3'd0, 1'b0, 32'hABC3_D5FE, 32'h0, 0, 1'b0);
    check("R4 vpn", {12'd0, r_vpn}, 32'h0000_0ABC);
    check("R4 flags sect/glob/xn/sh", {28'd0, r_sect, r_glob, r_xn, r_sh}, 32'b1011);
    check("R4 ap", {29'd0, r_ap}, 32'b101);
    check("R4 domain", {28'd0, r_dom}, 32'hF);
    check("R4 texcb", {27'd0, r_texcb}, 32'b10111);
    check("R4 asid", {24'd0, r_asid}, 32'h5A);

    // R8: small page fields
    do_walk(32'h0010_3ABC, 2'd0, 3'd0, 1'b0, 32'h0055_5421, 32'h7654_34FB, 0, 1'b0);
    check("R8 small vpn", {12'd0, r_vpn}, 32'h0000_0103);
    check("R8 small flags sect/glob/xn/sh", {28'd0, r_sect, r_glob, r_xn, r_sh}, 32'b0111);
    check("R8 small ap", {29'd0, r_ap}, 32'b011);
    check("R8 small texcb", {27'd0, r_texcb}, 32'b01110);
    check("R8 small domain from l1", {28'd0, r_dom}, 32'h1);

    // R8: large page fields
    do_walk(32'h0020_5678, 2'd0, 3'd0, 1'b0, 32'h0066_6001, 32'h9876_E811, 0, 1'b0);
    check("R8 large vpn", {12'd0, r_vpn}, 32'h0000_0020);
    check("R8 large flags glob/xn", {30'd0, r_glob, r_xn}, 32'b01);
    check("R8 large ap", {29'd0, r_ap}, 32'b001);
    check("R8 large texcb", {27'd0, r_texcb}, 32'b11000);

    // R7: level-2 translation fault domain and address
    do_walk(32'h0040_1234, 2'd2, 3'd0, 1'b0, 32'h0077_7061, 32'h0, 0, 1'b0);
    check("R7 domain", {28'd0, r_fdom}, 32'h3);
    check("R7 fault va", r_fva, 32'h0040_1234);
    check("R7 fetch", {31'd0, r_fetch}, 32'd1);

    // R10: request while busy is flagged and ignored
    do_walk(32'h1234_5678, 2'd0, 3'd0, 1'b0, 32'hABC0_0402, 32'h0, 0, 1'b1);
    check("R10 req_err", {31'd0, r_err}, 32'd1);
    check("R10 walk unchanged addr", a1, 32'h4000_048C);
    check("R10 walk unchanged vpn", {12'd0, r_vpn}, 32'h0000_0123);

    // R12: memory back-pressure
    do_walk(32'h0010_3000, 2'd0, 3'd0, 1'b0, 32'h0055_5421, 32'h7654_3012, 3, 1'b0);
    check("R12 addr stable", {31'd0, stable_err}, 32'd0);
    check("R12 l2 addr", a2, 32'h0055_540C);
    check("R12 result pfn", {12'd0, r_pfn}, 32'h0007_6543);
    mem_req_ready = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule